// File: doc/BRIEF.md
# Address-Space-Qualified Paired Register Load Unit

This unit carries out the paired-register load-alternate operation of a 64-bit processor core. A request brings a byte address, an 8-bit address space identifier (ASI), a destination register number and the two privilege bits of the core (privileged, hyperprivileged). The unit decides whether the request may run at all. A disallowed request produces a single-cycle trap with a cause code and no side effects. An allowed request issues one or two reads on a simple request/response memory port and then writes an even/odd pair of destination registers through a one-write-per-cycle register file port.

Two ASI values select a 128-bit quad mode. In this mode the unit reads two 64-bit words from a 16-byte-aligned address, and one of the two values byte-reverses each word. Every other ASI selects the default mode: two 32-bit reads at the address and the address plus 4, each zero-extended into its register. Register 0 is never written. When 0 is named as the destination, only register 1 is loaded, from the upper half of the pair. The unit also screens plain (non-paired) accesses: a plain access that names a quad ASI is an illegal instruction.

Top module: `ldpair_unit`

## Requirements
- R1: A paired request with an odd destination number traps with cause 1 (illegal). It issues no memory request and makes no register write.
- R2: A plain request (`req_pair`=0) with ASI 0x24 or 0x2C traps with cause 1. A plain request with any other ASI ends with a `done` pulse and no memory request.
- R3: A paired request with an ASI below 0x80 while `priv`=0 traps with cause 2 (privilege).
- R4: A paired request with an ASI from 0x30 to 0x7F while `hpriv`=0 traps with cause 2. ASIs below 0x30 do not need `hpriv`.
- R5: In quad mode (ASI 0x24 or 0x2C) an address with a nonzero `addr[3:0]` traps with cause 3 (alignment). In default mode a nonzero `addr[1:0]` traps with cause 3.
- R6: In quad mode both reads are 8-byte (`mem_req_size`=1), at `addr` and `addr+8`. Register rd receives the first word and rd+1 the second.
- R7: With ASI 0x2C each 64-bit word is byte-reversed (byte 0 exchanged with byte 7, and so on) before it is written. With ASI 0x24 it is written as read.
- R8: In default mode both reads are 4-byte (`mem_req_size`=0), at `addr` and `addr+4`. Each register receives bits [31:0] of its response, zero-extended to 64 bits.
- R9: With rd=0 only one read is issued, at `addr+8` (quad) or `addr+4` (default), and only register 1 is written. Register 0 is never written.
- R10: Cause priority is illegal over privilege over alignment. A trap is a one-cycle `trap_valid` pulse in the cycle after acceptance. It comes with no memory request and no register write, and never with `done`.
- R11: All reads complete before the first register write. Writes go one per cycle in consecutive cycles, rd first and then rd+1.
- R12: `busy` is high from the cycle after acceptance through the last write cycle. `done` pulses for one cycle after the last write. A request presented while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, sampled when idle |
| req_pair | input | 1 | 1: paired load; 0: plain access screening |
| req_addr | input | ADDR_W | Byte address |
| req_asi | input | 8 | Address space identifier |
| req_rd | input | RD_W | Destination register number |
| priv | input | 1 | Core is privileged |
| hpriv | input | 1 | Core is hyperprivileged |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| trap_valid | output | 1 | One-cycle trap pulse |
| trap_code | output | 2 | Trap cause: 1 illegal, 2 privilege, 3 alignment |
| mem_req_valid | output | 1 | Memory read request (one cycle) |
| mem_req_addr | output | ADDR_W | Read address |
| mem_req_size | output | 1 | 1: 8-byte read; 0: 4-byte read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | DATA_W | Read data |
| rf_we | output | 1 | Register write enable |
| rf_waddr | output | RD_W | Register write number |
| rf_wdata | output | DATA_W | Register write data |

## Verification
The hardest situation to bring about is a second request arriving while a quad load is still waiting on a slow memory response. The stimulus pulses `req_valid` with a different destination in the middle of a long-latency read. The reference queues then show that no extra read or write appears. The bench also builds requests that break two or three rules at once (odd register, missing privilege, misalignment), so that only the cause priority picks the reported code. It varies the response latency from one to four cycles, so the write order is checked against reads that finish at different times.

// File: rtl/ldpair_pkg.sv
package ldpair_pkg;

    localparam int ASI_W = 8;
    localparam logic [ASI_W-1:0] ASI_QUAD_NATIVE  = 8'h24;
    localparam logic [ASI_W-1:0] ASI_QUAD_SWAPPED = 8'h2C;
    localparam logic [ASI_W-1:0] ASI_OPEN_FLOOR   = 8'h80;
    localparam logic [ASI_W-1:0] ASI_HYPER_FLOOR  = 8'h30;

    typedef enum logic [1:0] {
        TRAP_NONE    = 2'd0,
        TRAP_ILLEGAL = 2'd1,
        TRAP_PRIV    = 2'd2,
        TRAP_ALIGN   = 2'd3
    } trap_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_WR_EVEN,
        ST_WR_ODD
    } state_e;

    typedef struct packed {
        logic quad;     // 64-bit reads, 16-byte alignment
        logic swap;     // byte-reverse each word
        logic single;   // destination 0: only the odd register
        logic screen;   // plain access, no memory work
    } plan_t;

    function automatic logic is_quad_asi(input logic [ASI_W-1:0] asi);
        return (asi == ASI_QUAD_NATIVE) || (asi == ASI_QUAD_SWAPPED);
    endfunction

    function automatic logic needs_priv(input logic [ASI_W-1:0] asi);
        return asi < ASI_OPEN_FLOOR;
    endfunction

    function automatic logic needs_hyper(input logic [ASI_W-1:0] asi);
        return (asi >= ASI_HYPER_FLOOR) && (asi < ASI_OPEN_FLOOR);
    endfunction

    // Highest-priority cause wins: illegal, then privilege, then alignment.
    function automatic trap_e pick_trap(input logic illegal,
                                        input logic no_priv,
                                        input logic misaligned);
        if (illegal)    return TRAP_ILLEGAL;
        if (no_priv)    return TRAP_PRIV;
        if (misaligned) return TRAP_ALIGN;
        return TRAP_NONE;
    endfunction

endpackage

// File: rtl/ldpair_decode.sv
module ldpair_decode
    import ldpair_pkg::*;
#(
    parameter int RD_W = 5
) (
    input  logic             pair,
    input  logic [3:0]       addr_lo,
    input  logic [ASI_W-1:0] asi,
    input  logic [RD_W-1:0]  rd,
    input  logic             priv,
    input  logic             hpriv,
    output trap_e            fault,
    output plan_t            plan
);

    logic quad;
    logic illegal;
    logic no_priv;
    logic misaligned;

    always_comb begin
        quad       = is_quad_asi(asi);
        // Plain accesses: only the quad identifiers are refused.
        // Paired accesses: an odd destination is refused.
        illegal    = pair ? rd[0] : quad;
        no_priv    = pair && ((needs_priv(asi) && !priv) ||
                              (needs_hyper(asi) && !hpriv));
        misaligned = pair && (quad ? (addr_lo != 4'd0)
                                   : (addr_lo[1:0] != 2'd0));
        fault      = pick_trap(illegal, no_priv, misaligned);

        plan.quad   = quad;
        plan.swap   = (asi == ASI_QUAD_SWAPPED);
        plan.single = (rd == '0);
        plan.screen = !pair;
    end

endmodule

// File: rtl/ldpair_bswap.sv
module ldpair_bswap #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    localparam int BYTES = DATA_W / 8;

    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        assign dout[8*b +: 8] = din[8*(BYTES-1-b) +: 8];
    end

endmodule

// File: rtl/ldpair_fsm.sv
module ldpair_fsm
    import ldpair_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int DATA_W = 64,
    parameter int RD_W   = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [RD_W-1:0]   req_rd,
    input  trap_e             fault,
    input  plan_t             plan,
    output logic              busy,
    output logic              done,
    output logic              trap_valid,
    output logic [1:0]        trap_code,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic              mem_req_size,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    input  logic [DATA_W-1:0] mem_rsp_swapped,
    output logic              rf_we,
    output logic [RD_W-1:0]   rf_waddr,
    output logic [DATA_W-1:0] rf_wdata
);

    localparam int HALF_W = DATA_W / 2;
    localparam logic [ADDR_W-1:0] STEP_QUAD = ADDR_W'(DATA_W / 8);
    localparam logic [ADDR_W-1:0] STEP_HALF = ADDR_W'(HALF_W / 8);

    state_e            state_q;
    plan_t             plan_q;
    logic [ADDR_W-1:0] base_q;
    logic [RD_W-1:0]   rd_q;
    logic              upper_q;     // current read targets the odd register
    logic [DATA_W-1:0] word_even_q;
    logic [DATA_W-1:0] word_odd_q;
    logic              done_q;
    logic              trap_q;
    trap_e             code_q;

    logic [ADDR_W-1:0] step;
    logic [DATA_W-1:0] fetched;

    always_comb begin
        step = plan_q.quad ? STEP_QUAD : STEP_HALF;
        if (plan_q.quad)
            fetched = plan_q.swap ? mem_rsp_swapped : mem_rsp_data;
        else
            fetched = {{(DATA_W-HALF_W){1'b0}}, mem_rsp_data[HALF_W-1:0]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            plan_q      <= '0;
            base_q      <= '0;
            rd_q        <= '0;
            upper_q     <= 1'b0;
            word_even_q <= '0;
            word_odd_q  <= '0;
            done_q      <= 1'b0;
            trap_q      <= 1'b0;
            code_q      <= TRAP_NONE;
        end else begin
            done_q <= 1'b0;
            trap_q <= 1'b0;
            code_q <= TRAP_NONE;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (fault != TRAP_NONE) begin
                            trap_q <= 1'b1;
                            code_q <= fault;
                        end else if (plan.screen) begin
                            done_q <= 1'b1;
                        end else begin
                            plan_q  <= plan;
                            base_q  <= req_addr;
                            rd_q    <= req_rd;
                            upper_q <= plan.single;
                            state_q <= ST_REQ;
                        end
                    end
                end
                ST_REQ: state_q <= ST_WAIT;
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (upper_q) begin
                            word_odd_q <= fetched;
                            state_q    <= plan_q.single ? ST_WR_ODD : ST_WR_EVEN;
                        end else begin
                            word_even_q <= fetched;
                            upper_q     <= 1'b1;
                            state_q     <= ST_REQ;
                        end
                    end
                end
                ST_WR_EVEN: state_q <= ST_WR_ODD;
                ST_WR_ODD: begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy          = (state_q != ST_IDLE);
        done          = done_q;
        trap_valid    = trap_q;
        trap_code     = code_q;
        mem_req_valid = (state_q == ST_REQ);
        mem_req_addr  = base_q + (upper_q ? step : '0);
        mem_req_size  = plan_q.quad;
        rf_we         = (state_q == ST_WR_EVEN) || (state_q == ST_WR_ODD);
        rf_waddr      = (state_q == ST_WR_ODD) ? {rd_q[RD_W-1:1], 1'b1} : rd_q;
        rf_wdata      = (state_q == ST_WR_ODD) ? word_odd_q : word_even_q;
    end

    // R9: register 0 is never a write target
    a_r9_no_reg0_write: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> (rf_waddr != '0));

    // R11: the even write is followed at once by the odd write of the pair
    a_r11_pair_order: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WR_EVEN) |=> (rf_we && (rf_waddr == ($past(rf_waddr) + 1'b1))));

    // R12: completion is a single-cycle pulse
    a_r12_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10: a trap leaves the unit idle and never coincides with completion
    a_r10_trap_idle: assert property (@(posedge clk) disable iff (rst)
        trap_valid |-> (!busy && !done && !rf_we && !mem_req_valid));

    // R6: quad-mode reads are always 8-byte aligned
    a_r6_quad_read_aligned: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_size) |-> (mem_req_addr[2:0] == 3'd0));

    // R11: no write while a read is outstanding
    a_r11_reads_first: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |=> !rf_we);

endmodule

// File: rtl/ldpair_unit.sv
module ldpair_unit
    import ldpair_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int DATA_W = 64,
    parameter int RD_W   = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_pair,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_asi,
    input  logic [RD_W-1:0]   req_rd,
    input  logic              priv,
    input  logic              hpriv,
    output logic              busy,
    output logic              done,
    output logic              trap_valid,
    output logic [1:0]        trap_code,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic              mem_req_size,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              rf_we,
    output logic [RD_W-1:0]   rf_waddr,
    output logic [DATA_W-1:0] rf_wdata
);

    trap_e             fault;
    plan_t             plan;
    logic [DATA_W-1:0] rsp_swapped;

    ldpair_decode #(.RD_W(RD_W)) u_decode (
        .pair    (req_pair),
        .addr_lo (req_addr[3:0]),
        .asi     (req_asi),
        .rd      (req_rd),
        .priv    (priv),
        .hpriv   (hpriv),
        .fault   (fault),
        .plan    (plan)
    );

    ldpair_bswap #(.DATA_W(DATA_W)) u_bswap (
        .din  (mem_rsp_data),
        .dout (rsp_swapped)
    );

    ldpair_fsm #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .RD_W   (RD_W)
    ) u_fsm (
        .clk             (clk),
        .rst             (rst),
        .req_valid       (req_valid),
        .req_addr        (req_addr),
        .req_rd          (req_rd),
        .fault           (fault),
        .plan            (plan),
        .busy            (busy),
        .done            (done),
        .trap_valid      (trap_valid),
        .trap_code       (trap_code),
        .mem_req_valid   (mem_req_valid),
        .mem_req_addr    (mem_req_addr),
        .mem_req_size    (mem_req_size),
        .mem_rsp_valid   (mem_rsp_valid),
        .mem_rsp_data    (mem_rsp_data),
        .mem_rsp_swapped (rsp_swapped),
        .rf_we           (rf_we),
        .rf_waddr        (rf_waddr),
        .rf_wdata        (rf_wdata)
    );

endmodule

// File: tb/tb_ldpair_unit.sv
module tb_ldpair_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_pair = 1'b0;
    logic [63:0] req_addr = '0;
    logic [7:0]  req_asi = '0;
    logic [4:0]  req_rd = '0;
    logic        priv = 1'b1;
    logic        hpriv = 1'b1;
    logic        busy, done, trap_valid, mem_req_valid, mem_req_size, rf_we;
    logic [1:0]  trap_code;
    logic [63:0] mem_req_addr, rf_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic [4:0]  rf_waddr;

    always #5 clk = ~clk;

    ldpair_unit dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_pair(req_pair),
        .req_addr(req_addr), .req_asi(req_asi), .req_rd(req_rd),
        .priv(priv), .hpriv(hpriv), .busy(busy), .done(done),
        .trap_valid(trap_valid), .trap_code(trap_code),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_req_size(mem_req_size), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .rf_we(rf_we), .rf_waddr(rf_waddr),
        .rf_wdata(rf_wdata)
    );

    int          checks = 0;
    int          failures = 0;
    string       tag = "R0";
    int          exp_trap = 0;
    bit          ev_seen = 0;
    bit          mon_on = 0;
    int          mem_lat = 1;
    logic [4:0]  q_wa[$];
    logic [63:0] q_wd[$];
    logic [63:0] q_ra[$];
    logic        q_rs[$];

    task automatic chk(input bit ok, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [63:0] mem_val(input logic [63:0] a);
        return {a[31:0] ^ 32'h5A3C_96F0, a[31:0] + 32'h1357_0000};
    endfunction

    function automatic logic [63:0] rev64(input logic [63:0] v);
        logic [63:0] r;
        for (int b = 0; b < 8; b++) r[8*b +: 8] = v[8*(7-b) +: 8];
        return r;
    endfunction

    function automatic int trap_of(input bit pair, input logic [63:0] a,
                                   input logic [7:0] asi, input logic [4:0] rd,
                                   input bit p, input bit hp);
        bit quad = (asi == 8'h24) || (asi == 8'h2C);
        if (!pair) return quad ? 1 : 0;
        if (rd[0]) return 1;
        if ((asi < 8'h80 && !p) || (asi >= 8'h30 && asi < 8'h80 && !hp)) return 2;
        if (quad ? (a[3:0] != 4'd0) : (a[1:0] != 2'd0)) return 3;
        return 0;
    endfunction

    function automatic logic [63:0] loaded(input logic [63:0] a, input logic [7:0] asi);
        logic [63:0] m = mem_val(a);
        if (asi == 8'h24) return m;
        if (asi == 8'h2C) return rev64(m);
        return {32'h0, m[31:0]};
    endfunction

    // Memory model: answers each read after mem_lat cycles.
    initial begin
        bit          pend = 0;
        int          cnt = 0;
        logic [63:0] pa = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (pend) begin
                if (cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = mem_val(pa);
                    pend = 0;
                end else cnt--;
            end
            if (mon_on && mem_req_valid) begin
                if (q_ra.size() == 0) begin
                    chk(0, "unexpected memory request", mem_req_addr, 64'h0);
                end else begin
                    chk(mem_req_addr == q_ra[0], "read address", mem_req_addr, q_ra[0]);
                    chk(mem_req_size == q_rs[0], "read size", {63'h0, mem_req_size}, {63'h0, q_rs[0]});
                    void'(q_ra.pop_front());
                    void'(q_rs.pop_front());
                end
                pend = 1;
                cnt  = mem_lat - 1;
                pa   = mem_req_addr;
            end
        end
    end

    // Reference comparison on every clock
    initial begin
        forever begin
            @(negedge clk);
            if (mon_on) begin
                if (rf_we) begin
                    chk(busy == 1'b1, "R12 busy during write", {63'h0, busy}, 64'h1);
                    chk(q_ra.size() == 0, "R11 write before reads done", q_ra.size(), 64'h0);
                    if (q_wa.size() == 0) begin
                        chk(0, "unexpected register write", {59'h0, rf_waddr}, 64'h0);
                    end else begin
                        chk(rf_waddr == q_wa[0], "write register", {59'h0, rf_waddr}, {59'h0, q_wa[0]});
                        chk(rf_wdata == q_wd[0], "write data", rf_wdata, q_wd[0]);
                        void'(q_wa.pop_front());
                        void'(q_wd.pop_front());
                    end
                end
                if (trap_valid) begin
                    chk(trap_code == exp_trap[1:0], "trap code", {62'h0, trap_code}, 64'(exp_trap));
                    ev_seen = 1;
                end
                if (done) begin
                    chk(exp_trap == 0, "R10 done where trap expected", 64'h0, 64'(exp_trap));
                    chk(q_wa.size() == 0, "R12 done with writes pending", q_wa.size(), 64'h0);
                    chk(busy == 1'b0, "R12 busy at done", {63'h0, busy}, 64'h0);
                    ev_seen = 1;
                end
            end
        end
    end

    task automatic run_op(input string t, input bit pair, input logic [63:0] a,
                          input logic [7:0] asi, input logic [4:0] rd,
                          input bit p, input bit hp, input int lat, input bit inject);
        bit quad = (asi == 8'h24) || (asi == 8'h2C);
        logic [63:0] step = quad ? 64'd8 : 64'd4;
        int waited = 0;
        tag      = t;
        mem_lat  = lat;
        exp_trap = trap_of(pair, a, asi, rd, p, hp);
        ev_seen  = 0;
        if (exp_trap == 0 && pair) begin
            if (rd == 5'd0) begin
                q_ra.push_back(a + step); q_rs.push_back(quad);
                q_wa.push_back(5'd1);     q_wd.push_back(loaded(a + step, asi));
            end else begin
                q_ra.push_back(a);        q_rs.push_back(quad);
                q_ra.push_back(a + step); q_rs.push_back(quad);
                q_wa.push_back(rd);       q_wd.push_back(loaded(a, asi));
                q_wa.push_back(rd + 5'd1); q_wd.push_back(loaded(a + step, asi));
            end
        end
        req_valid = 1'b1; req_pair = pair; req_addr = a; req_asi = asi;
        req_rd = rd; priv = p; hpriv = hp;
        @(negedge clk);
        req_valid = 1'b0;
        while (!ev_seen && waited < 400) begin
            if (inject && waited == 2) begin
                req_valid = 1'b1; req_pair = 1'b1; req_addr = 64'h7000;
                req_asi = 8'h24; req_rd = 5'd10;
            end else req_valid = 1'b0;
            @(negedge clk);
            waited++;
        end
        req_valid = 1'b0;
        chk(ev_seen, "operation never finished", 64'(waited), 64'h0);
        chk(q_ra.size() == 0 && q_wa.size() == 0, "leftover expected events",
            64'(q_ra.size() + q_wa.size()), 64'h0);
        q_ra.delete(); q_rs.delete(); q_wa.delete(); q_wd.delete();
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        tag = "R12";
        chk(!busy && !done && !trap_valid && !rf_we && !mem_req_valid,
            "reset state", {59'h0, busy, done, trap_valid, rf_we, mem_req_valid}, 64'h0);
        mon_on = 1;

        run_op("R6",  1, 64'h1000, 8'h24, 5'd2,  1, 1, 1, 0);
        run_op("R7",  1, 64'h2010, 8'h2C, 5'd4,  1, 1, 2, 0);
        run_op("R8",  1, 64'h3004, 8'h80, 5'd6,  0, 0, 3, 0);
        run_op("R8",  1, 64'h300C, 8'h14, 5'd12, 1, 0, 1, 0);
        run_op("R9",  1, 64'h4000, 8'h24, 5'd0,  1, 1, 2, 0);
        run_op("R9",  1, 64'h5008, 8'h81, 5'd0,  0, 0, 1, 0);
        run_op("R6",  1, 64'hFFF0, 8'h2C, 5'd30, 1, 1, 4, 0);
        run_op("R1",  1, 64'h1000, 8'h24, 5'd3,  1, 1, 1, 0);
        run_op("R2",  0, 64'h1000, 8'h24, 5'd2,  1, 1, 1, 0);
        run_op("R2",  0, 64'h1000, 8'h2C, 5'd2,  1, 1, 1, 0);
        run_op("R2",  0, 64'h1001, 8'h04, 5'd3,  0, 0, 1, 0);
        run_op("R3",  1, 64'h1000, 8'h04, 5'd2,  0, 1, 1, 0);
        run_op("R4",  1, 64'h1000, 8'h40, 5'd2,  1, 0, 1, 0);
        run_op("R4",  1, 64'h1000, 8'h30, 5'd2,  1, 0, 1, 0);
        run_op("R4",  1, 64'h6000, 8'h2F, 5'd8,  1, 0, 2, 0);
        run_op("R5",  1, 64'h1008, 8'h24, 5'd2,  1, 1, 1, 0);
        run_op("R5",  1, 64'h1002, 8'h80, 5'd2,  1, 1, 1, 0);
        run_op("R10", 1, 64'h1003, 8'h50, 5'd5,  0, 0, 1, 0);
        run_op("R10", 1, 64'h1004, 8'h2C, 5'd6,  0, 1, 1, 0);
        run_op("R11", 1, 64'h8000, 8'h24, 5'd20, 1, 1, 4, 1);
        run_op("R12", 1, 64'h9004, 8'h88, 5'd22, 1, 1, 3, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule